// File: doc/BRIEF.md
# Lockable Secure Register Bank for an Inter-Processor Interrupt Block

This block is the APB slave that holds the control registers of an inter-processor interrupt controller. Only secure transactions may change its state. A nonsecure write is dropped and answered with PSLVERR. A nonsecure read returns zero.

A set-once lock bit freezes a chosen group of registers until the next power-on reset. The following registers stay writable after the lock:
- the interrupt status register, which is write-one-to-clear;
- a safety-check scratch register;
- the lock register itself.

Three events feed the status register:
- a nonsecure write attempt;
- a correctable memory error;
- an uncorrectable memory error.

For each of the two memory-error kinds, a capture register keeps the address of the first error. A masked OR of the status bits drives one interrupt line. When the error-control enable bit is set, an access to an undecoded offset returns PSLVERR. Every access completes with zero wait states.

Top module: `ipi_regbank`

## Requirements
- R1: A write with PPROT[1]=1 (nonsecure) changes no register except status bit 0, and gets PSLVERR=1 in its access phase. A nonsecure read returns PRDATA=0.
- R2: Writing 1 to bit 0 of the lock register (offset 0x090) sets the lock. Afterwards the lock reads 1 and no write clears it. Only reset clears it.
- R3: While the lock is set, writes to error control (0x000), interrupt enable (0x018), interrupt disable (0x01C), ECC control (0x094) and aperture security (0x0DC) are discarded.
- R4: Writing 1 to a bit of the status register (0x010) clears that bit. This also works while the lock is set.
- R5: The safety-check register (0x030, 32 bits) can be read and written whether or not the lock is set.
- R6: When bit 0 of error control is 1, an access to an undecoded offset gets PSLVERR=1. When that bit is 0, the same access gets PSLVERR=0.
- R7: The correctable-error capture register (0x098) and the uncorrectable-error capture register (0x0A4) take the error address on the event that sets status bit 1 or bit 2 respectively. Later events leave them unchanged while that status bit stays set.
- R8: Clearing status bit 1 or bit 2 resets the matching capture register to 0, so the next error is captured.
- R9: The mask register (0x014, read-only) resets to all ones. Writing 1 to an enable bit clears the matching mask bit, and writing 1 to a disable bit sets it. The irq output is the OR of the status bits that are not masked.
- R10: PREADY is always 1. PSLVERR is 1 only in an access phase (PSEL and PENABLE both 1).
- R11: Status bit 0 is set by a nonsecure write, bit 1 by ce_evt and bit 2 by ue_evt. Each event takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write |
| pprot | input | 3 | APB protection; bit 1 set means nonsecure |
| paddr | input | AW | APB byte offset |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error response |
| ce_evt | input | 1 | Correctable error event pulse |
| ue_evt | input | 1 | Uncorrectable error event pulse |
| err_addr | input | CAW | Address of the failing access for an event |
| irq | output | 1 | Interrupt output |

## Verification
PRDATA and PSLVERR are combinational and due in the same access phase. The monitor samples them at the falling edge inside that phase and compares them with the item that the driver queued. A register write, a lock, a status clear or an error event takes effect at the rising edge that ends the access or the event pulse. Its result is therefore checked by a later read through the queue. The irq line is checked directly once the driver task has returned.

// File: rtl/ipi_regbank.sv
module ipi_regbank #(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int CAW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [2:0]     pprot,
  input  logic [AW-1:0]  paddr,
  input  logic [DW-1:0]  pwdata,
  output logic [DW-1:0]  prdata,
  output logic           pready,
  output logic           pslverr,
  input  logic           ce_evt,
  input  logic           ue_evt,
  input  logic [CAW-1:0] err_addr,
  output logic           irq
);
  localparam int NI = 3;
  localparam logic [AW-1:0] A_ERRCTL = AW'('h000);
  localparam logic [AW-1:0] A_STAT   = AW'('h010);
  localparam logic [AW-1:0] A_MASK   = AW'('h014);
  localparam logic [AW-1:0] A_ENA    = AW'('h018);
  localparam logic [AW-1:0] A_DIS    = AW'('h01C);
  localparam logic [AW-1:0] A_SAFE   = AW'('h030);
  localparam logic [AW-1:0] A_LOCK   = AW'('h090);
  localparam logic [AW-1:0] A_ECC    = AW'('h094);
  localparam logic [AW-1:0] A_CECAP  = AW'('h098);
  localparam logic [AW-1:0] A_UECAP  = AW'('h0A4);
  localparam logic [AW-1:0] A_APER   = AW'('h0DC);

  logic          err_en_q, lock_q;
  logic [NI-1:0] stat_q, mask_q;
  logic [DW-1:0] safe_q, ecc_q, aper_q;
  logic [CAW-1:0] ce_cap_q, ue_cap_q;

  logic          hit, lockable;
  logic [DW-1:0] rd;

  wire acc    = psel & penable;
  wire ns     = pprot[1];
  wire unused_prot = pprot[2] ^ pprot[0];

  always_comb begin
    hit = 1'b1;
    lockable = 1'b0;
    rd = '0;
    case (paddr)
      A_ERRCTL: begin rd = DW'(err_en_q); lockable = 1'b1; end
      A_STAT:   rd = DW'(stat_q);
      A_MASK:   rd = DW'(mask_q);
      A_ENA:    lockable = 1'b1;
      A_DIS:    lockable = 1'b1;
      A_SAFE:   rd = safe_q;
      A_LOCK:   rd = DW'(lock_q);
      A_ECC:    begin rd = ecc_q; lockable = 1'b1; end
      A_CECAP:  rd = DW'(ce_cap_q);
      A_UECAP:  rd = DW'(ue_cap_q);
      A_APER:   begin rd = aper_q; lockable = 1'b1; end
      default:  hit = 1'b0;
    endcase
  end

  wire wr_ok = acc & pwrite & ~ns & hit & ~(lockable & lock_q);
  wire [NI-1:0] stat_clr = (wr_ok && paddr == A_STAT) ? pwdata[NI-1:0] : '0;
  wire [NI-1:0] stat_set = {ue_evt, ce_evt, acc & pwrite & ns};

  assign pready  = 1'b1;
  assign pslverr = acc & ((pwrite & ns) | (err_en_q & ~hit));
  assign prdata  = (acc & ~pwrite & ~ns) ? rd : '0;
  assign irq     = |(stat_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_en_q <= 1'b0;
      lock_q   <= 1'b0;
      stat_q   <= '0;
      mask_q   <= '1;
      safe_q   <= '0;
      ecc_q    <= '0;
      aper_q   <= '0;
      ce_cap_q <= '0;
      ue_cap_q <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      if (wr_ok) begin
        case (paddr)
          A_ERRCTL: err_en_q <= pwdata[0];
          A_ENA:    mask_q   <= mask_q & ~pwdata[NI-1:0];
          A_DIS:    mask_q   <= mask_q | pwdata[NI-1:0];
          A_SAFE:   safe_q   <= pwdata;
          A_LOCK:   lock_q   <= lock_q | pwdata[0];
          A_ECC:    ecc_q    <= pwdata;
          A_APER:   aper_q   <= pwdata;
          default: ;
        endcase
      end
      if (ce_evt && !stat_q[1])          ce_cap_q <= err_addr;
      else if (stat_clr[1] && !ce_evt)   ce_cap_q <= '0;
      if (ue_evt && !stat_q[2])          ue_cap_q <= err_addr;
      else if (stat_clr[2] && !ue_evt)   ue_cap_q <= '0;
    end
  end

  p_ns_write_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pwrite && ns) |-> pslverr);
  p_ns_write_safe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pwrite && ns) |=> $stable(safe_q) && $stable(lock_q) && $stable(mask_q));
  p_ns_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pwrite && ns) |-> (prdata == '0));
  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_locked_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(err_en_q) && $stable(ecc_q) && $stable(aper_q) && $stable(mask_q));
  p_ce_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[1] |=> (stat_q[1] -> $stable(ce_cap_q)));
  p_ue_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[2] |=> (stat_q[2] -> $stable(ue_cap_q)));
  p_err_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable));
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) pready);
endmodule

// File: tb/ipi_regbank_tb_top.sv
module ipi_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [2:0]  pprot = 3'b000;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        ce_evt = 1'b0, ue_evt = 1'b0;
  logic [31:0] err_addr = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    logic        cmp_data;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  ipi_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pprot(pprot), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .err_addr(err_addr), .irq(irq)
  );

  always @(negedge clk) begin
    if (psel && penable && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pslverr !== e.err || pready !== 1'b1) begin
        failures++;
        $display("FAIL %s pslverr/pready act=%b/%b exp=%b/1", e.tag, pslverr, pready, e.err);
      end
      if (e.cmp_data) begin
        checks++;
        if (prdata !== e.data) begin
          failures++;
          $display("FAIL %s prdata act=%h exp=%h", e.tag, prdata, e.data);
        end
      end
    end
  end

  task automatic apb(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic ns, input logic [31:0] ed, input logic ee, input string tag);
    exp_t e;
    e.data = ed; e.err = ee; e.cmp_data = ~w; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #2;
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
    pprot = ns ? 3'b010 : 3'b000;
    @(posedge clk); #2 penable = 1'b1;
    @(posedge clk); #2;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    apb(1'b1, a, d, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] ed, input string tag);
    apb(1'b0, a, '0, 1'b0, ed, 1'b0, tag);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic evt(input logic ce, input logic [31:0] a);
    @(posedge clk); #2;
    ce_evt = ce; ue_evt = ~ce; err_addr = a;
    @(posedge clk); #2;
    ce_evt = 1'b0; ue_evt = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk(irq, 1'b0, "reset irq R9");
    rd(12'h090, 32'h0, "reset lock R2");
    rd(12'h014, 32'h7, "reset mask R9");
    rd(12'h010, 32'h0, "reset status R11");

    // R6 decode error enable
    rd(12'h044, 32'h0, "undecoded, check off R6");
    wr(12'h000, 32'h1, "enable decode check R6");
    rd(12'h000, 32'h1, "errctl readback R6");
    apb(1'b0, 12'h044, '0, 1'b0, 32'h0, 1'b1, "undecoded read err R6");
    apb(1'b1, 12'h048, 32'h5, 1'b0, 32'h0, 1'b1, "undecoded write err R6");

    // R1 nonsecure access, R11 bit 0
    apb(1'b1, 12'h030, 32'hDEAD, 1'b1, 32'h0, 1'b1, "ns write err R1");
    rd(12'h030, 32'h0, "ns write dropped R1");
    rd(12'h010, 32'h1, "ns write sets status bit0 R11");
    apb(1'b0, 12'h010, '0, 1'b1, 32'h0, 1'b0, "ns read zero R1");

    // R9 mask and irq, R4 clear
    chk(irq, 1'b0, "masked status no irq R9");
    wr(12'h018, 32'h1, "enable bit0 R9");
    rd(12'h014, 32'h6, "mask after enable R9");
    chk(irq, 1'b1, "unmasked status irq R9");
    wr(12'h010, 32'h1, "w1c bit0 R4");
    rd(12'h010, 32'h0, "status cleared R4");
    chk(irq, 1'b0, "irq drops R9");

    // R7 first-error capture
    evt(1'b1, 32'h123);
    rd(12'h098, 32'h123, "ce capture R7");
    evt(1'b1, 32'h456);
    rd(12'h098, 32'h123, "ce capture holds first R7");
    evt(1'b0, 32'h77);
    rd(12'h0A4, 32'h77, "ue capture R7");
    rd(12'h010, 32'h6, "status bits 1,2 R11");

    // R8 rearm
    wr(12'h010, 32'h2, "clear ce status R8");
    rd(12'h098, 32'h0, "ce capture cleared R8");
    rd(12'h0A4, 32'h77, "ue capture kept R8");
    evt(1'b1, 32'h456);
    rd(12'h098, 32'h456, "ce capture rearmed R8");

    // R3 setup then lock, R2
    wr(12'h094, 32'hA5, "ecc ctrl R3");
    wr(12'h0DC, 32'h11, "aperture R3");
    wr(12'h090, 32'h1, "set lock R2");
    rd(12'h090, 32'h1, "lock set R2");
    wr(12'h090, 32'h0, "try clear lock R2");
    rd(12'h090, 32'h1, "lock sticky R2");

    wr(12'h000, 32'h0, "locked errctl write R3");
    rd(12'h000, 32'h1, "errctl frozen R3");
    apb(1'b0, 12'h044, '0, 1'b0, 32'h0, 1'b1, "decode err still on R3");
    wr(12'h094, 32'h5A, "locked ecc write R3");
    rd(12'h094, 32'hA5, "ecc frozen R3");
    wr(12'h0DC, 32'h22, "locked aperture write R3");
    rd(12'h0DC, 32'h11, "aperture frozen R3");
    wr(12'h01C, 32'h1, "locked disable write R3");
    rd(12'h014, 32'h6, "mask frozen R3");
    wr(12'h018, 32'h6, "locked enable write R3");
    rd(12'h014, 32'h6, "mask frozen enable R3");

    // R5, R4 after lock
    wr(12'h030, 32'hBEEF, "safety write locked R5");
    rd(12'h030, 32'hBEEF, "safety readback R5");
    wr(12'h010, 32'h6, "w1c after lock R4");
    rd(12'h010, 32'h0, "status clear after lock R4");
    chk(pready, 1'b1, "pready idle R10");
    chk(pslverr, 1'b0, "no err outside access R10");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule